// File: doc/BRIEF.md
# Region Memory Protection Checker

This block watches every instruction fetch and every data access of a processor and decides whether each one is allowed. There is no address translation. It holds two region tables of its own: one for instructions and one for data. Each region has a base, a power-of-two size and permission bits. A fetch needs execute permission. A data read needs read permission and a data write needs write permission. An access that hits no valid region is refused.

A refused access is reported one cycle later on a registered violation output. That output carries the faulting address and a tag saying which side faulted. Software fills the tables through a single write port. Each region is set up with one base-word write and one attribute-word write. Software then arms the checker.

The checker is a two-state machine. In state SETUP, nothing is reported. The ARM transition (an arm write with bit 0 set) moves it to state GUARD. GUARD holds on every later cycle and is left only through reset, which returns the machine to SETUP.

Top module: `mprot_guard`

## Requirements
- R1: After reset, `viol_valid` is 0 and every region of both tables is invalid. An armed checker with no region written refuses every access.
- R2: While in SETUP, `viol_valid` stays 0 whatever accesses are presented.
- R3: A write with `cfg_kind` = 2 and `cfg_wdata[0]` = 1 moves the checker to GUARD from the next cycle on. Later arm writes with bit 0 clear leave it in GUARD, and only reset returns it to SETUP.
- R4: A fetch is allowed only when the lowest-numbered valid instruction region that contains its address has the execute bit set. The execute bit is attribute bit 1.
- R5: A data read needs the read bit (attribute bit 1) of the deciding data region. A data write needs the write bit (attribute bit 2) of that region.
- R6: An access whose address lies in no valid region of its own table is a violation.
- R7: The attribute word encodes the size as log2 of the byte count in bits 8:3. Values below 6 act as 6 (64 bytes) and values above 32 act as 32 (the whole space). Base bits below the region size are ignored. The base word takes the base address from bits 31:6. The valid bit is attribute bit 0.
- R8: Where regions overlap, the lowest-numbered matching region alone decides the permission.
- R9: A violation is shown on `viol_valid` in the cycle after the access, with `viol_addr` set to the faulting address. `viol_data` is 0 for a fetch and 1 for a data access. When both sides fault in the same cycle, the fetch is reported.
- R10: A region write takes effect for accesses from the next cycle. An access in the same cycle as the write is judged by the old contents.
- R11: Writes select a table with `cfg_dside`: 0 for instruction, 1 for data. A write to one table never changes the verdict of the other. `cfg_kind` is 0 for a base word and 1 for an attribute word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 base word, 1 attribute word, 2 arm |
| cfg_dside | input | 1 | Table select: 0 instruction, 1 data |
| cfg_idx | input | IDX_W | Region index |
| cfg_wdata | input | 32 | Write data |
| ifetch_valid | input | 1 | Fetch present this cycle |
| ifetch_addr | input | 32 | Fetch address |
| data_valid | input | 1 | Data access present this cycle |
| data_addr | input | 32 | Data address |
| data_write | input | 1 | 1 for a write, 0 for a read |
| viol_valid | output | 1 | Registered violation indication |
| viol_addr | output | 32 | Faulting address |
| viol_data | output | 1 | 0 fetch fault, 1 data fault |

## Verification
Table state is not visible at the ports, so a bad entry shows up only through the verdict on the next access that lands in its range. That verdict appears one cycle after the access. The bench therefore sweeps addresses just inside and just outside every region edge on both sides, so that a wrong base, mask or permission bit is seen at the first access that probes it. A state machine stuck in SETUP, or one that leaves GUARD, shows as a missing or extra `viol_valid` on the very next faulting access. A broken priority chain shows at the overlap addresses, where a lower- and a higher-numbered region disagree.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

    localparam int ADDR_W  = 32;
    localparam int GRAN_LG = 6;

    typedef enum logic [1:0] {
        CFG_BASE = 2'd0,
        CFG_ATTR = 2'd1,
        CFG_ARM  = 2'd2
    } cfg_kind_e;

    typedef enum logic {
        ST_SETUP = 1'b0,
        ST_GUARD = 1'b1
    } guard_state_e;

    typedef struct packed {
        logic       valid;
        logic       perm_a;
        logic       perm_w;
        logic [5:0] size_lg;
    } attr_t;

    // Address bits that take part in the comparison for a given size code.
    function automatic logic [ADDR_W-1:0] region_mask(input logic [5:0] s);
        if (s >= 6'd32)
            return '0;
        else if (s < 6'(GRAN_LG))
            return {ADDR_W{1'b1}} << GRAN_LG;
        else
            return {ADDR_W{1'b1}} << s;
    endfunction

endpackage

// File: rtl/mprot_ctrl.sv
module mprot_ctrl
    import mprot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    output logic guarding
);

    guard_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_SETUP;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SETUP: if (arm_req) state_d = ST_GUARD;
            ST_GUARD: state_d = ST_GUARD;
        endcase
    end

    always_comb begin
        guarding = (state_q == ST_GUARD);
    end

endmodule

// File: rtl/mprot_table.sv
module mprot_table
    import mprot_pkg::*;
#(
    parameter  int N  = 8,
    parameter  int IW = 3,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [IW-1:0]     wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              hit,
    output logic              allow
);

    logic [N-1:0] match;
    attr_t        attr_all [N];
    logic [SW-1:0] sel;
    attr_t        sel_attr;

    for (genvar g = 0; g < N; g++) begin : g_ent
        logic [ADDR_W-1:GRAN_LG] base_r;
        attr_t                   attr_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= '0;
                attr_r <= '0;
            end else if (wr_en && wr_idx == IW'(g)) begin
                if (wr_kind == 2'(CFG_BASE))
                    base_r <= wr_data[ADDR_W-1:GRAN_LG];
                else if (wr_kind == 2'(CFG_ATTR))
                    attr_r <= '{valid:   wr_data[0],
                                perm_a:  wr_data[1],
                                perm_w:  wr_data[2],
                                size_lg: wr_data[8:3]};
            end
        end

        assign attr_all[g] = attr_r;
        assign match[g]    = attr_r.valid &&
            (((acc_addr ^ {base_r, {GRAN_LG{1'b0}}}) & region_mask(attr_r.size_lg)) == '0);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) sel = SW'(i);
        end
    end

    assign sel_attr = attr_all[sel];
    assign hit      = |match;
    assign allow    = hit && (acc_write ? sel_attr.perm_w : sel_attr.perm_a);

endmodule

// File: rtl/mprot_guard.sv
module mprot_guard
    import mprot_pkg::*;
#(
    parameter  int NUM_I = 8,
    parameter  int NUM_D = 8,
    localparam int NMAX  = (NUM_I > NUM_D) ? NUM_I : NUM_D,
    localparam int IDX_W = (NMAX > 1) ? $clog2(NMAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_kind,
    input  logic              cfg_dside,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              ifetch_valid,
    input  logic [ADDR_W-1:0] ifetch_addr,
    input  logic              data_valid,
    input  logic [ADDR_W-1:0] data_addr,
    input  logic              data_write,
    output logic              viol_valid,
    output logic [ADDR_W-1:0] viol_addr,
    output logic              viol_data
);

    logic guarding;
    logic arm_req;
    logic i_hit, i_allow, d_hit, d_allow;
    logic i_fault, d_fault;

    assign arm_req = cfg_we && (cfg_kind == 2'(CFG_ARM)) && cfg_wdata[0];

    mprot_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_req  (arm_req),
        .guarding (guarding)
    );

    mprot_table #(.N(NUM_I), .IW(IDX_W)) u_itab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we && !cfg_dside),
        .wr_kind   (cfg_kind),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_wdata),
        .acc_addr  (ifetch_addr),
        .acc_write (1'b0),
        .hit       (i_hit),
        .allow     (i_allow)
    );

    mprot_table #(.N(NUM_D), .IW(IDX_W)) u_dtab (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we && cfg_dside),
        .wr_kind   (cfg_kind),
        .wr_idx    (cfg_idx),
        .wr_data   (cfg_wdata),
        .acc_addr  (data_addr),
        .acc_write (data_write),
        .hit       (d_hit),
        .allow     (d_allow)
    );

    assign i_fault = ifetch_valid && !i_allow;
    assign d_fault = data_valid && !d_allow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_addr  <= '0;
            viol_data  <= 1'b0;
        end else begin
            viol_valid <= guarding && (i_fault || d_fault);
            viol_addr  <= i_fault ? ifetch_addr : data_addr;
            viol_data  <= !i_fault;
        end
    end

endmodule

// File: rtl/mprot_guard_chk.sv
module mprot_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [1:0]  cfg_kind,
    input logic [31:0] cfg_wdata,
    input logic        ifetch_valid,
    input logic [31:0] ifetch_addr,
    input logic        data_valid,
    input logic [31:0] data_addr,
    input logic        viol_valid,
    input logic [31:0] viol_addr,
    input logic        viol_data,
    input logic        guarding,
    input logic        i_hit,
    input logic        i_allow,
    input logic        d_hit
);

    p_setup_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !guarding |=> !viol_valid);

    p_arm_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_kind == 2'd2 && cfg_wdata[0]) |=> guarding);

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        guarding |=> guarding);

    p_nomatch_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (guarding && ifetch_valid && !i_hit) |=> (viol_valid && !viol_data));

    p_nomatch_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (guarding && data_valid && !d_hit && !(ifetch_valid && !i_allow))
            |=> (viol_valid && viol_data));

    p_fetch_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && !viol_data) |-> ($past(ifetch_valid) && viol_addr == $past(ifetch_addr)));

    p_data_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_data) |-> ($past(data_valid) && viol_addr == $past(data_addr)));

    p_fetch_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_data) |-> $past(!ifetch_valid || i_allow));

endmodule

bind mprot_guard mprot_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_kind     (cfg_kind),
    .cfg_wdata    (cfg_wdata),
    .ifetch_valid (ifetch_valid),
    .ifetch_addr  (ifetch_addr),
    .data_valid   (data_valid),
    .data_addr    (data_addr),
    .viol_valid   (viol_valid),
    .viol_addr    (viol_addr),
    .viol_data    (viol_data),
    .guarding     (guarding),
    .i_hit        (i_hit),
    .i_allow      (i_allow),
    .d_hit        (d_hit)
);

// File: tb/mprot_guard_test.sv
`timescale 1ns/1ps
module mprot_guard_test;

    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_kind = '0;
    logic        cfg_dside = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        ifetch_valid = 1'b0;
    logic [31:0] ifetch_addr = '0;
    logic        data_valid = 1'b0;
    logic [31:0] data_addr = '0;
    logic        data_write = 1'b0;
    logic        viol_valid;
    logic [31:0] viol_addr;
    logic        viol_data;

    int vectors = 0;
    int errors  = 0;

    logic [31:0] m_base [2][NR];
    logic [8:0]  m_attr [2][NR];
    bit          m_armed;

    always #4 clk = ~clk;

    mprot_guard #(.NUM_I(NR), .NUM_D(NR)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_dside(cfg_dside), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .ifetch_valid(ifetch_valid), .ifetch_addr(ifetch_addr),
        .data_valid(data_valid), .data_addr(data_addr), .data_write(data_write),
        .viol_valid(viol_valid), .viol_addr(viol_addr), .viol_data(viol_data)
    );

    // Reference verdict computed from the requirement text (R4, R5, R7, R8).
    function automatic bit m_allow(int side, logic [31:0] a, bit wr);
        for (int i = 0; i < NR; i++) begin
            logic [8:0]  at = m_attr[side][i];
            int          s  = int'(at[8:3]);
            logic [31:0] mk;
            if (!at[0]) continue;
            if (s < 6) s = 6;
            if (s > 32) s = 32;
            mk = (s == 32) ? 32'h0 : (32'hFFFF_FFFF << s);
            if (((a ^ m_base[side][i]) & mk) == 32'h0)
                return wr ? at[2] : at[1];
        end
        return 1'b0;
    endfunction

    function automatic void m_update(int kind, int side, int idx, logic [31:0] d);
        if (kind == 0) m_base[side][idx] = d & 32'hFFFF_FFC0;
        else if (kind == 1) m_attr[side][idx] = d[8:0];
        else if (kind == 2 && d[0]) m_armed = 1'b1;
    endfunction

    task automatic check(bit ev, logic [31:0] ea, bit et, string req);
        vectors++;
        if (viol_valid !== ev || (ev && (viol_addr !== ea || viol_data !== et))) begin
            errors++;
            $display("FAIL %s: got valid=%0b addr=%h data=%0b, expected valid=%0b addr=%h data=%0b",
                     req, viol_valid, viol_addr, viol_data, ev, ea, et);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < NR; i++) begin
                m_base[s][i] = '0;
                m_attr[s][i] = '0;
            end
        m_armed = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drives an access (and optionally a config write in the same cycle),
    // judges it with the model as it stood before the write, and samples one cycle later.
    task automatic step(bit we, int kind, int side, int idx, logic [31:0] wd,
                        bit ifv, logic [31:0] ia, bit dv, logic [31:0] da, bit dw,
                        string req);
        bit fi, fd, ev;
        @(negedge clk);
        cfg_we = we; cfg_kind = 2'(kind); cfg_dside = side[0];
        cfg_idx = 2'(idx); cfg_wdata = wd;
        ifetch_valid = ifv; ifetch_addr = ia;
        data_valid = dv; data_addr = da; data_write = dw;
        fi = ifv && !m_allow(0, ia, 1'b0);
        fd = dv && !m_allow(1, da, dw);
        ev = m_armed && (fi || fd);
        @(negedge clk);
        cfg_we = 1'b0; ifetch_valid = 1'b0; data_valid = 1'b0;
        if (we) m_update(kind, side, idx, wd);
        check(ev, fi ? ia : da, !fi, req);
    endtask

    task automatic cfg(int kind, int side, int idx, logic [31:0] wd);
        step(1'b1, kind, side, idx, wd, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, "R11 cfg");
    endtask

    task automatic acc(bit ifv, logic [31:0] ia, bit dv, logic [31:0] da, bit dw, string req);
        step(1'b0, 0, 0, 0, 32'h0, ifv, ia, dv, da, dw, req);
    endtask

    function automatic logic [31:0] sweep_base(int k);
        case (k)
            0: return 32'h0000_0000;
            1: return 32'h0000_1000;
            2: return 32'h0000_1040;
            3: return 32'h0000_2000;
            4: return 32'h0000_5040;
            default: return 32'h8000_0000;
        endcase
    endfunction

    function automatic logic [31:0] sweep_off(int k);
        case (k)
            0: return 32'hFFFF_FFFF;
            1: return 32'h0;
            2: return 32'h3F;
            3: return 32'h40;
            4: return 32'hFF;
            5: return 32'h100;
            6: return 32'hFFF;
            default: return 32'h1000;
        endcase
    endfunction

    initial begin
        apply_reset();
        @(negedge clk);
        // R1: reset state
        check(1'b0, 32'h0, 1'b0, "R1 reset");
        // R2: SETUP reports nothing
        acc(1'b1, 32'h0000_0100, 1'b0, 32'h0, 1'b0, "R2 setup fetch");
        acc(1'b0, 32'h0, 1'b1, 32'h0000_2000, 1'b1, "R2 setup write");
        acc(1'b1, 32'hFFFF_FFC0, 1'b1, 32'h1234_5678, 1'b0, "R2 setup dual");
        // R3: arm, then R1/R6: no region valid so everything faults
        cfg(2, 0, 0, 32'h1);
        acc(1'b1, 32'h0000_0000, 1'b0, 32'h0, 1'b0, "R1 R6 empty fetch");
        acc(1'b0, 32'h0, 1'b1, 32'h0000_1234, 1'b0, "R1 R6 empty read");
        acc(1'b0, 32'h0, 1'b1, 32'hFFFF_FFC0, 1'b1, "R6 empty write");
        acc(1'b1, 32'h0000_0040, 1'b1, 32'h0000_0080, 1'b1, "R9 dual fetch first");
        cfg(2, 0, 0, 32'h0);
        acc(1'b0, 32'h0, 1'b1, 32'h0000_4444, 1'b0, "R3 disarm ignored");

        // Reprogram from a fresh reset
        apply_reset();
        cfg(0, 0, 0, 32'h0000_1000); cfg(1, 0, 0, 32'h063);
        cfg(0, 0, 1, 32'h0000_0000); cfg(1, 0, 1, 32'h1F9);
        cfg(0, 0, 2, 32'h0000_1040); cfg(1, 0, 2, 32'h031);
        cfg(0, 0, 3, 32'h8000_0000); cfg(1, 0, 3, 32'h013);
        cfg(0, 1, 0, 32'h0000_2000); cfg(1, 1, 0, 32'h043);
        cfg(0, 1, 1, 32'h0000_2000); cfg(1, 1, 1, 32'h06F);
        cfg(0, 1, 2, 32'h8000_0000); cfg(1, 1, 2, 32'h0FD);
        cfg(0, 1, 3, 32'h0000_5047); cfg(1, 1, 3, 32'h017);
        acc(1'b1, 32'h0000_0010, 1'b1, 32'h0000_9000, 1'b1, "R2 programmed setup");
        cfg(2, 1, 0, 32'h1);

        // Sweep around every region edge: R4 R5 R6 R7 R8 R9
        for (int b = 0; b < 6; b++) begin
            for (int o = 0; o < 8; o++) begin
                logic [31:0] a = sweep_base(b) + sweep_off(o);
                acc(1'b1, a, 1'b0, 32'h0, 1'b0, "R4 R7 R8 fetch");
                acc(1'b0, 32'h0, 1'b1, a, 1'b0, "R5 R7 R8 read");
                acc(1'b0, 32'h0, 1'b1, a, 1'b1, "R5 R6 write");
                acc(1'b1, a, 1'b1, a ^ 32'h0000_2000, 1'b1, "R9 dual");
            end
        end

        // R10: same-cycle write sees old contents, next cycle sees new
        step(1'b1, 1, 1, 0, 32'h000, 1'b0, 32'h0, 1'b1, 32'h0000_2010, 1'b1, "R10 old entry");
        acc(1'b0, 32'h0, 1'b1, 32'h0000_2010, 1'b1, "R10 new entry");
        // R11: data-table writes leave instruction verdicts unchanged
        cfg(1, 1, 1, 32'h000);
        acc(1'b1, 32'h0000_1040, 1'b0, 32'h0, 1'b0, "R11 fetch kept");
        acc(1'b0, 32'h0, 1'b1, 32'h0000_2010, 1'b0, "R11 data removed");
        step(1'b1, 1, 0, 0, 32'h061, 1'b1, 32'h0000_1000, 1'b0, 32'h0, 1'b0, "R10 exec old");
        acc(1'b1, 32'h0000_1000, 1'b1, 32'h8000_0004, 1'b1, "R10 exec new");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule